// File: doc/BRIEF.md
# Transmit Packet Buffer

This block holds outgoing frames for a network transmit path. A host processor fills it through a small write-only register bus. The host picks a buffer channel, then pushes the frame as 32-bit words through one fixed data port. It writes the frame's byte length for that channel and finally sets a start bit. The block then sends exactly that many bytes on a byte-wide streaming output that uses valid, last and ready handshakes.

Each channel keeps its own words and its own length, so a frame stays loaded until the host overwrites it. While a frame is being sent, new start requests are refused. Data-port writes are dropped in that window and raise a sticky overrun flag. When the final byte has been taken, the busy indication falls and a sticky done flag rises.

Top module: `tx_pkt_buffer`

## Requirements
- R1: After reset `tx_busy`, `tx_done`, `tx_overrun` and `m_valid` are all 0. Channel 0 is selected and every stored length is 0.
- R2: Register offset 0 selects the transfer mode in bit 0: 0 means host (CPU) transfer and 1 means DMA transfer. Reset selects DMA. Data-port writes are stored only in CPU mode and are ignored in DMA mode.
- R3: Register offset 1 selects the channel. A write of a value below NUM_CH selects that channel and moves its fill position back to word 0. A write of a larger value is ignored completely.
- R4: Each write to register offset 2 stores its 32-bit word at the current fill position of the selected channel, and the position then advances. Once DEPTH words have been written, further words are dropped.
- R5: Register offset 3 sets the byte length of the selected channel. A value above DEPTH*4 is stored as DEPTH*4.
- R6: A write to register offset 4 with bit 0 set, made while idle with a nonzero length on the selected channel, starts a transfer. `tx_busy` and `m_valid` are 1 in the cycle that follows the write's clock edge.
- R7: Byte n of a frame is bits [8*(n mod 4)+7 : 8*(n mod 4)] of word n/4, so bytes leave lowest first. Exactly the programmed number of bytes is sent, `m_last` marks the final one, and the unused bytes of the last word are never sent.
- R8: A byte is consumed only on a clock edge where `m_valid` and `m_ready` are both 1. While `m_ready` is 0, `m_valid`, `m_data` and `m_last` hold their values.
- R9: In the cycle after the final byte is accepted, `tx_busy` and `m_valid` are 0 and `tx_done` is 1. `tx_done` stays 1 until the next accepted start, which clears it.
- R10: A start request made while a transfer is active is ignored. The running transfer keeps its channel, length and data, even if the length register is rewritten meanwhile.
- R11: A data-port write in CPU mode while a transfer is active stores nothing and sets `tx_overrun`. The flag stays 1 until the next accepted start, which clears it.
- R12: A start request on a channel whose length is 0 sends no byte, leaves `tx_busy` at 0 and sets `tx_done` in the following cycle.
- R13: Channels are independent. Loading one channel leaves the words and length of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 32 | Register write data |
| tx_busy | output | 1 | A transfer is in progress (the start bit, read back) |
| tx_done | output | 1 | Sticky: the last transfer finished |
| tx_overrun | output | 1 | Sticky: a data-port write was dropped during a transfer |
| m_data | output | 8 | Outgoing byte |
| m_valid | output | 1 | `m_data` holds a byte to send |
| m_last | output | 1 | Current byte is the final byte of the frame |
| m_ready | input | 1 | Downstream accepts the byte on this edge |

## Verification
Every register write takes effect at the clock edge that captures it. Its result is therefore checked at the falling edge that follows: busy, valid and the first byte after a start, done and zero busy after a zero-length start, and the overrun flag after a dropped write. A byte accepted at an edge is answered one falling edge later by the next byte or, after the last byte, by busy low and done high. The bench sets `m_ready` and reads the outputs at each falling edge and compares them with a model of the stored words and lengths. During a stall it checks that the byte held on the output has not changed since the previous falling edge.

// File: rtl/txpb_pkg.sv
package txpb_pkg;

    // Register offsets on the host write bus
    localparam int OFF_MODE  = 0;
    localparam int OFF_CHSEL = 1;
    localparam int OFF_DATA  = 2;
    localparam int OFF_LEN   = 3;
    localparam int OFF_CTRL  = 4;

    localparam int WORD_BYTES = 4;

    typedef enum logic {
        XFER_CPU = 1'b0,
        XFER_DMA = 1'b1
    } xfer_mode_e;

endpackage

// File: rtl/txpb_regs.sv
module txpb_regs
    import txpb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 3,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int WI_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CAP   = DEPTH * WORD_BYTES,
    localparam int LEN_W = $clog2(CAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy_i,
    output logic              wr_en_o,
    output logic [CH_W-1:0]   wr_ch_o,
    output logic [WI_W-1:0]   wr_idx_o,
    output logic [31:0]       wr_data_o,
    output logic              start_o,
    output logic [CH_W-1:0]   start_ch_o,
    output logic [LEN_W-1:0]  start_len_o,
    output logic              overrun_o
);

    localparam int PTR_W = $clog2(DEPTH + 1);

    typedef struct packed {
        xfer_mode_e                      mode;
        logic [CH_W-1:0]                 sel;
        logic [PTR_W-1:0]                wptr;
        logic [NUM_CH-1:0][LEN_W-1:0]    len;
        logic                            overrun;
    } regs_t;

    regs_t r_q, r_d;

    logic hit_mode, hit_chsel, hit_data, hit_len, hit_ctrl;

    always_comb begin
        hit_mode  = reg_wr && (reg_addr == ADDR_W'(OFF_MODE));
        hit_chsel = reg_wr && (reg_addr == ADDR_W'(OFF_CHSEL));
        hit_data  = reg_wr && (reg_addr == ADDR_W'(OFF_DATA));
        hit_len   = reg_wr && (reg_addr == ADDR_W'(OFF_LEN));
        hit_ctrl  = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
    end

    always_comb begin
        r_d     = r_q;
        wr_en_o = 1'b0;
        start_o = 1'b0;

        if (hit_mode) begin
            r_d.mode = xfer_mode_e'(reg_wdata[0]);
        end

        if (hit_chsel && (reg_wdata < 32'(NUM_CH))) begin
            r_d.sel  = CH_W'(reg_wdata);
            r_d.wptr = '0;
        end

        if (hit_data && (r_q.mode == XFER_CPU)) begin
            if (busy_i) begin
                r_d.overrun = 1'b1;
            end else if (r_q.wptr < PTR_W'(DEPTH)) begin
                wr_en_o  = 1'b1;
                r_d.wptr = r_q.wptr + PTR_W'(1);
            end
        end

        if (hit_len) begin
            r_d.len[r_q.sel] = (reg_wdata > 32'(CAP)) ? LEN_W'(CAP) : LEN_W'(reg_wdata);
        end

        if (hit_ctrl && reg_wdata[0] && !busy_i) begin
            start_o     = 1'b1;
            r_d.overrun = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode    <= XFER_DMA;
            r_q.sel     <= '0;
            r_q.wptr    <= '0;
            r_q.len     <= '0;
            r_q.overrun <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_ch_o     = r_q.sel;
    assign wr_idx_o    = WI_W'(r_q.wptr);
    assign wr_data_o   = reg_wdata;
    assign start_ch_o  = r_q.sel;
    assign start_len_o = r_q.len[r_q.sel];
    assign overrun_o   = r_q.overrun;

    // R11: a host-mode data write during a transfer leaves the overrun flag set
    a_r11_overrun_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_data && (r_q.mode == XFER_CPU) && busy_i) |=> overrun_o);

    // R5: the length handed to the sequencer never exceeds the channel capacity
    a_r5_len_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        start_len_o <= LEN_W'(CAP));

    // R2: DMA mode never produces a store
    a_r2_dma_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == XFER_DMA) |-> !wr_en_o);

endmodule

// File: rtl/txpb_store.sv
module txpb_store
    import txpb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DEPTH  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int WI_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [CH_W-1:0] wr_ch_i,
    input  logic [WI_W-1:0] wr_idx_i,
    input  logic [31:0]     wr_data_i,
    input  logic [CH_W-1:0] rd_ch_i,
    input  logic [WI_W-1:0] rd_idx_i,
    output logic [31:0]     rd_word_o
);

    typedef logic [NUM_CH-1:0][DEPTH-1:0][31:0] mem_t;

    mem_t              mem_q, mem_d;
    logic [NUM_CH-1:0] ch_we;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_we[c] = wr_en_i && (wr_ch_i == CH_W'(c));

        // R13: a channel that is not written keeps its contents
        a_r13_channel_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_we[c] |=> $stable(mem_q[c]));
    end

    always_comb begin
        mem_d = mem_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_we[c]) begin
                mem_d[c][wr_idx_i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_word_o = mem_q[rd_ch_i][rd_idx_i];

endmodule

// File: rtl/txpb_stream.sv
module txpb_stream
    import txpb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DEPTH  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int WI_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CAP   = DEPTH * WORD_BYTES,
    localparam int LEN_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  start_ch_i,
    input  logic [LEN_W-1:0] start_len_i,
    output logic [CH_W-1:0]  rd_ch_o,
    output logic [WI_W-1:0]  rd_idx_o,
    input  logic [31:0]      rd_word_i,
    output logic [7:0]       m_data_o,
    output logic             m_valid_o,
    output logic             m_last_o,
    input  logic             m_ready_i,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CH_W-1:0]  ch;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] bcnt;
    } seq_t;

    seq_t s_q, s_d;

    logic [WORD_BYTES-1:0][7:0] lane;
    logic                       at_end;

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        assign lane[l] = rd_word_i[8*l +: 8];
    end

    assign at_end = (s_q.bcnt == (s_q.len - LEN_W'(1)));

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            if (start_len_i == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.done = 1'b0;
                s_d.ch   = start_ch_i;
                s_d.len  = start_len_i;
                s_d.bcnt = '0;
            end
        end else if (s_q.busy && m_ready_i) begin
            if (at_end) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.bcnt = s_q.bcnt + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ch_o   = s_q.ch;
    assign rd_idx_o  = WI_W'(s_q.bcnt >> 2);
    assign m_data_o  = lane[s_q.bcnt[1:0]];
    assign m_valid_o = s_q.busy;
    assign m_last_o  = s_q.busy && at_end;
    assign busy_o    = s_q.busy;
    assign done_o    = s_q.done;

    // R10: the register block only issues a start while the sequencer is idle
    a_r10_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_q.busy);

    // R8: a stalled byte is held unchanged
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));

    // R9: accepting the last byte ends the transfer with done raised
    a_r9_finish_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && m_ready_i && m_last_o) |=> (!m_valid_o && done_o));

    // R7: the byte counter stays inside the programmed frame
    a_r7_count_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (s_q.bcnt < s_q.len));

endmodule

// File: rtl/tx_pkt_buffer.sv
module tx_pkt_buffer
    import txpb_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              tx_overrun,
    output logic [7:0]        m_data,
    output logic              m_valid,
    output logic              m_last,
    input  logic              m_ready
);

    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WI_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CAP   = DEPTH * WORD_BYTES;
    localparam int LEN_W = $clog2(CAP + 1);

    logic             wr_en;
    logic [CH_W-1:0]  wr_ch;
    logic [WI_W-1:0]  wr_idx;
    logic [31:0]      wr_data;
    logic             start;
    logic [CH_W-1:0]  start_ch;
    logic [LEN_W-1:0] start_len;
    logic [CH_W-1:0]  rd_ch;
    logic [WI_W-1:0]  rd_idx;
    logic [31:0]      rd_word;

    txpb_regs #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .busy_i      (tx_busy),
        .wr_en_o     (wr_en),
        .wr_ch_o     (wr_ch),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data),
        .start_o     (start),
        .start_ch_o  (start_ch),
        .start_len_o (start_len),
        .overrun_o   (tx_overrun)
    );

    txpb_store #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_ch_i   (wr_ch),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_ch_i   (rd_ch),
        .rd_idx_i  (rd_idx),
        .rd_word_o (rd_word)
    );

    txpb_stream #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .start_ch_i  (start_ch),
        .start_len_i (start_len),
        .rd_ch_o     (rd_ch),
        .rd_idx_o    (rd_idx),
        .rd_word_i   (rd_word),
        .m_data_o    (m_data),
        .m_valid_o   (m_valid),
        .m_last_o    (m_last),
        .m_ready_i   (m_ready),
        .busy_o      (tx_busy),
        .done_o      (tx_done)
    );

endmodule

// File: tb/tx_pkt_buffer_tb.sv
module tx_pkt_buffer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 2;
    localparam int DPT  = 16;
    localparam int CAPB = DPT * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        tx_busy, tx_done, tx_overrun;
    logic [7:0]  m_data;
    logic        m_valid, m_last;
    logic        m_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [31:0] mdl_mem [NCH][DPT];
    int  mdl_len [NCH];
    int  mdl_sel = 0;
    int  mdl_wptr = 0;
    bit  mdl_dma = 1'b1;
    bit  exp_busy = 1'b0;
    int  exp_ch = 0;
    int  exp_len = 0;

    tx_pkt_buffer #(.NUM_CH(NCH), .DEPTH(DPT), .ADDR_W(3)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .tx_busy    (tx_busy),
        .tx_done    (tx_done),
        .tx_overrun (tx_overrun),
        .m_data     (m_data),
        .m_valid    (m_valid),
        .m_last     (m_last),
        .m_ready    (m_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int ch, input int n);
        return 8'(mdl_mem[ch][n/4] >> (8*(n%4)));
    endfunction

    // Called at a falling edge; returns at the falling edge after the capture edge.
    task automatic wr(input int addr, input logic [31:0] data);
        reg_wr    = 1'b1;
        reg_addr  = 3'(addr);
        reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        case (addr)
            0: mdl_dma = data[0];
            1: if (data < NCH) begin mdl_sel = int'(data); mdl_wptr = 0; end
            2: if (!mdl_dma && !exp_busy && mdl_wptr < DPT) begin
                   mdl_mem[mdl_sel][mdl_wptr] = data;
                   mdl_wptr++;
               end
            3: mdl_len[mdl_sel] = (data > CAPB) ? CAPB : int'(data);
            default: ;
        endcase
    endtask

    task automatic start_tx();
        int l;
        l = mdl_len[mdl_sel];
        exp_ch  = mdl_sel;
        exp_len = l;
        wr(4, 32'h1);
        if (l == 0) begin
            chk(tx_done == 1'b1, "R12 done", 32'(tx_done), 1);
            chk(tx_busy == 1'b0 && m_valid == 1'b0, "R12 idle", 32'(tx_busy), 0);
        end else begin
            chk(tx_busy == 1'b1, "R6 busy", 32'(tx_busy), 1);
            chk(m_valid == 1'b1, "R6 valid", 32'(m_valid), 1);
            chk(tx_done == 1'b0, "R9 done cleared", 32'(tx_done), 0);
            chk(tx_overrun == 1'b0, "R11 overrun cleared", 32'(tx_overrun), 0);
            exp_busy = 1'b1;
        end
    endtask

    task automatic collect(input int pct, input string tag);
        int n = 0;
        int guard = 0;
        bit pstall = 1'b0;
        logic [7:0] pdata = '0;
        while (n < exp_len && guard < 5000) begin
            m_ready = (($urandom % 100) < pct);
            if (pstall) begin
                chk(m_valid == 1'b1 && m_data == pdata, "R8 hold", 32'(m_data), 32'(pdata));
            end
            if (m_valid && m_ready) begin
                chk(m_data == exp_byte(exp_ch, n), tag, 32'(m_data), 32'(exp_byte(exp_ch, n)));
                chk(m_last == (n == exp_len - 1), "R7 last", 32'(m_last), 32'(n == exp_len - 1));
                n++;
                pstall = 1'b0;
            end else begin
                pstall = m_valid;
                pdata  = m_data;
            end
            @(negedge clk);
            guard++;
        end
        m_ready = 1'b0;
        chk(n == exp_len, "R7 count", 32'(n), 32'(exp_len));
        chk(tx_busy == 1'b0 && m_valid == 1'b0, "R9 idle", 32'(tx_busy), 0);
        chk(tx_done == 1'b1, "R9 done", 32'(tx_done), 1);
        exp_busy = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d0;
        void'($urandom(32'd7719));
        for (int c = 0; c < NCH; c++) begin
            mdl_len[c] = 0;
            for (int w = 0; w < DPT; w++) mdl_mem[c][w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(tx_busy == 1'b0, "R1 busy", 32'(tx_busy), 0);
        chk(tx_done == 1'b0, "R1 done", 32'(tx_done), 0);
        chk(tx_overrun == 1'b0, "R1 overrun", 32'(tx_overrun), 0);
        chk(m_valid == 1'b0, "R1 valid", 32'(m_valid), 0);

        // R12: zero length at reset
        start_tx();
        repeat (2) @(negedge clk);
        chk(m_valid == 1'b0 && tx_done == 1'b1, "R12 no bytes", 32'(m_valid), 0);

        // R2: data writes ignored in DMA mode (the reset mode)
        wr(1, 0);
        wr(2, 32'hCAFEF00D);
        wr(2, 32'h12345678);
        wr(3, 8);
        wr(0, 0);
        start_tx();
        collect(100, "R2 data");

        // R7: directed little-endian frame with pad dropped
        wr(1, 0);
        wr(2, 32'h44332211);
        wr(2, 32'h88776655);
        wr(3, 7);
        start_tx();
        collect(100, "R7 data");

        // R5: length clamp on channel 1
        wr(1, 1);
        for (int w = 0; w < DPT; w++) wr(2, $urandom);
        wr(3, 100);
        start_tx();
        collect(60, "R5 data");

        // R3: out-of-range select ignored, fill continues
        wr(1, 1);
        wr(2, 32'hA1A2A3A4);
        wr(2, 32'hB1B2B3B4);
        wr(1, 7);
        wr(2, 32'hC1C2C3C4);
        wr(2, 32'hD1D2D3D4);
        wr(3, 16);
        start_tx();
        collect(50, "R3 data");

        // R13: channel 0 kept its words and length
        wr(1, 0);
        start_tx();
        collect(80, "R13 data");
        repeat (3) @(negedge clk);
        chk(tx_done == 1'b1, "R9 sticky", 32'(tx_done), 1);

        // R4: writes beyond DEPTH dropped
        wr(1, 0);
        for (int w = 0; w < DPT + 2; w++) wr(2, $urandom);
        wr(3, CAPB);
        start_tx();
        collect(60, "R4 data");

        // R10 / R11: stall, then disturb the running transfer
        wr(1, 1);
        wr(2, 32'h0F0E0D0C);
        wr(2, 32'h1B1A1918);
        wr(2, 32'h27262524);
        wr(3, 12);
        start_tx();
        d0 = m_data;
        wr(2, 32'hDEADBEEF);
        wr(3, 3);
        wr(4, 32'h1);
        chk(tx_busy == 1'b1, "R10 still busy", 32'(tx_busy), 1);
        chk(m_data == d0, "R8 stalled byte", 32'(m_data), 32'(d0));
        chk(tx_overrun == 1'b1, "R11 overrun set", 32'(tx_overrun), 1);
        collect(70, "R10 data");
        chk(tx_overrun == 1'b1, "R11 sticky", 32'(tx_overrun), 1);
        start_tx();
        collect(100, "R11 data");

        // random frames
        for (int it = 0; it < 24; it++) begin
            int ch;
            int nw;
            ch = int'($urandom % NCH);
            nw = 1 + int'($urandom % DPT);
            wr(1, 32'(ch));
            for (int w = 0; w < nw; w++) wr(2, $urandom);
            wr(3, 32'(nw * 4 - int'($urandom % 4)));
            start_tx();
            collect(30 + int'($urandom % 71), "R7 random");
        end

        summary();
        $finish;
    end

endmodule